// File: doc/BRIEF.md
# EEPROM Software Write-Protect Sequencer

This block sits between a bus write decoder and an EEPROM page loader. It looks at every qualified byte write (address and data) and decides whether that byte may go on to the page buffer. Fixed address/data command sequences arm writes, disarm protection, or do both. Each region of 2^REG_AW bytes, selected by the upper address bits, has its own protect flag. Any mix of regions may be protected at the same time.

The block also runs the write timing. Each write opens or restarts a byte-load window. When the window closes, a programming period follows. The protect flags change at the end of that programming period. A write to a protected region that has no command prefix in front of it still starts the full timing, but nothing is stored. The flags model non-volatile cells: reset does not clear them, and they start out cleared.

Top module: `wp_seq_top`

## Requirements
- R1: After reset, `busy`, `prog_busy` and `pass_valid` are low, and all protect flags start cleared.
- R2: A plain write to an unprotected region is forwarded on the cycle after it is accepted. `pass_valid` pulses for one cycle, and `pass_addr`/`pass_data` carry the write's address and data.
- R3: The arm prefix is three writes to one region, in this order: data 0xAA at region offset 0x05555, data 0x55 at offset 0x02AAA, data 0xA0 at offset 0x05555. The offset is the low REG_AW address bits; the region is the bits above them. These command bytes are never forwarded. The prefix sets the region's flag at the end of the programming period that follows, and not before.
- R4: A prefix with no data bytes after it still sets the flag at the end of the period.
- R5: A write to a protected region with no prefix before it is not forwarded. It still raises `busy` and runs a full load window and programming period.
- R6: After a prefix, data writes to that same region are forwarded until the period ends. The prefix does not unlock any other protected region.
- R7: At most PAGE_BYTES data bytes are forwarded per period. Bytes beyond that limit are dropped.
- R8: The disarm sequence is six writes to one region: 0xAA@0x05555, 0x55@0x02AAA, 0x80@0x05555, 0xAA@0x05555, 0x55@0x02AAA, 0x20@0x05555. It clears that region's flag at the end of the period. Data bytes that follow it in the same period are forwarded.
- R9: A write that breaks the expected next step of a sequence resets the matcher. That write is then handled as an ordinary write: it is forwarded if its region is unprotected.
- R10: Reset does not change any protect flag.
- R11: Each accepted write restarts a load window of LOAD_WIN cycles. If no write arrives for that long, PROG_CYC programming cycles follow. `busy` is high for exactly LOAD_WIN+PROG_CYC cycles after the last write, and `prog_busy` is high only during programming.
- R12: Writes offered during programming are ignored. They are not forwarded, they do not restart timing, and they do not advance a command sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (protect flags excluded) |
| wr_valid | input | 1 | Qualified byte write strobe |
| wr_addr | input | REG_AW+RSEL_W | Byte address; upper RSEL_W bits select the region |
| wr_data | input | 8 | Write data byte |
| pass_valid | output | 1 | One-cycle pulse: byte forwarded to page loader |
| pass_addr | output | REG_AW+RSEL_W | Address of forwarded byte |
| pass_data | output | 8 | Forwarded data byte |
| busy | output | 1 | Load window or programming in progress |
| prog_busy | output | 1 | Programming period in progress |
| prot_flags | output | N_REG | Per-region protect flags |

## Verification
The bench builds the block with two regions, a 20-cycle load window, a 40-cycle programming period and a 4-byte page limit. With these values, exact window lengths, a restart partway through a window, and writes landing inside the programming phase are all reachable in a few dozen cycles each. The small page limit lets one period overflow the byte cap. Two regions are enough to show that a prefix on one region leaves the other locked, and that flags set and clear independently across a reset.

// File: rtl/wp_pkg.sv
package wp_pkg;
    typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_PROG} phase_e;
    typedef enum logic [1:0] {PD_NONE, PD_SET, PD_CLR} pend_e;
    typedef enum logic [2:0] {ST_IDLE, ST_K1, ST_K2, ST_D3, ST_D4, ST_D5} step_e;

    localparam logic [7:0]  K_FIRST   = 8'hAA;
    localparam logic [7:0]  K_SECOND  = 8'h55;
    localparam logic [7:0]  K_ARM     = 8'hA0;
    localparam logic [7:0]  K_DIS     = 8'h80;
    localparam logic [7:0]  K_DIS_END = 8'h20;
    localparam logic [16:0] A_HI      = 17'h05555;
    localparam logic [16:0] A_LO      = 17'h02AAA;
endpackage

// File: rtl/wp_phase_timer.sv
module wp_phase_timer
    import wp_pkg::*;
#(
    parameter int LOAD_WIN = 7500,
    parameter int PROG_CYC = 500000
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hit,
    output phase_e phase_o,
    output logic   prog_end_o
);
    localparam int CMAX = (LOAD_WIN > PROG_CYC) ? LOAD_WIN : PROG_CYC;
    localparam int CT_W = $clog2(CMAX + 1);
    localparam logic [CT_W-1:0] LOAD_LD = CT_W'(LOAD_WIN - 1);
    localparam logic [CT_W-1:0] PROG_LD = CT_W'(PROG_CYC - 1);

    typedef struct packed {
        phase_e          ph;
        logic [CT_W-1:0] cnt;
    } tm_t;

    tm_t tm_d, tm_q;
    logic end_d;

    always_comb begin
        tm_d  = tm_q;
        end_d = 1'b0;
        if (hit) begin
            tm_d.ph  = PH_LOAD;
            tm_d.cnt = LOAD_LD;
        end else begin
            case (tm_q.ph)
                PH_LOAD: begin
                    if (tm_q.cnt == '0) begin
                        tm_d.ph  = PH_PROG;
                        tm_d.cnt = PROG_LD;
                    end else begin
                        tm_d.cnt = tm_q.cnt - 1'b1;
                    end
                end
                PH_PROG: begin
                    if (tm_q.cnt == '0) begin
                        tm_d.ph = PH_IDLE;
                        end_d   = 1'b1;
                    end else begin
                        tm_d.cnt = tm_q.cnt - 1'b1;
                    end
                end
                default: tm_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tm_q.ph  <= PH_IDLE;
            tm_q.cnt <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign phase_o    = tm_q.ph;
    assign prog_end_o = end_d;

    // R11
    win_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (tm_q.ph == PH_LOAD));

    // R11
    prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_q.ph == PH_PROG && tm_q.cnt != '0 && !hit) |=> (tm_q.ph == PH_PROG));

    // R11
    load_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_q.ph == PH_LOAD) |=> (tm_q.ph != PH_IDLE));
endmodule

// File: rtl/wp_cmd_match.sv
module wp_cmd_match
    import wp_pkg::*;
#(
    parameter int REG_AW = 17,
    parameter int RSEL_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              flush,
    input  logic [REG_AW-1:0] addr_lo,
    input  logic [RSEL_W-1:0] rsel,
    input  logic [7:0]        data,
    output logic              is_cmd_o,
    output logic              arm_o,
    output logic              dis_o
);
    typedef struct packed {
        step_e             step;
        logic [RSEL_W-1:0] rsel;
    } mt_t;

    mt_t mt_d, mt_q;
    logic at_hi, at_lo, same;

    assign at_hi = (addr_lo == REG_AW'(A_HI));
    assign at_lo = (addr_lo == REG_AW'(A_LO));
    assign same  = (mt_q.rsel == rsel);

    always_comb begin
        mt_d     = mt_q;
        is_cmd_o = 1'b0;
        arm_o    = 1'b0;
        dis_o    = 1'b0;
        if (flush) begin
            mt_d.step = ST_IDLE;
        end else if (hit) begin
            mt_d.step = ST_IDLE;
            case (mt_q.step)
                ST_IDLE: if (at_hi && data == K_FIRST) begin
                    is_cmd_o  = 1'b1;
                    mt_d.step = ST_K1;
                    mt_d.rsel = rsel;
                end
                ST_K1: if (same && at_lo && data == K_SECOND) begin
                    is_cmd_o  = 1'b1;
                    mt_d.step = ST_K2;
                end
                ST_K2: if (same && at_hi) begin
                    if (data == K_ARM) begin
                        is_cmd_o = 1'b1;
                        arm_o    = 1'b1;
                    end else if (data == K_DIS) begin
                        is_cmd_o  = 1'b1;
                        mt_d.step = ST_D3;
                    end
                end
                ST_D3: if (same && at_hi && data == K_FIRST) begin
                    is_cmd_o  = 1'b1;
                    mt_d.step = ST_D4;
                end
                ST_D4: if (same && at_lo && data == K_SECOND) begin
                    is_cmd_o  = 1'b1;
                    mt_d.step = ST_D5;
                end
                ST_D5: if (same && at_hi && data == K_DIS_END) begin
                    is_cmd_o = 1'b1;
                    dis_o    = 1'b1;
                end
                default: mt_d.step = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mt_q.step <= ST_IDLE;
            mt_q.rsel <= '0;
        end else begin
            mt_q <= mt_d;
        end
    end

    // R12
    step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !flush) |=> $stable(mt_q.step));

    // R9
    seq_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !flush && !is_cmd_o) |=> (mt_q.step == ST_IDLE));
endmodule

// File: rtl/wp_seq_top.sv
module wp_seq_top
    import wp_pkg::*;
#(
    parameter int N_REG      = 2,
    parameter int REG_AW     = 17,
    parameter int LOAD_WIN   = 7500,
    parameter int PROG_CYC   = 500000,
    parameter int PAGE_BYTES = 128,
    localparam int RSEL_W    = (N_REG > 1) ? $clog2(N_REG) : 1,
    localparam int AW        = REG_AW + RSEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [AW-1:0]    wr_addr,
    input  logic [7:0]       wr_data,
    output logic             pass_valid,
    output logic [AW-1:0]    pass_addr,
    output logic [7:0]       pass_data,
    output logic             busy,
    output logic             prog_busy,
    output logic [N_REG-1:0] prot_flags
);
    localparam int NB_W = $clog2(PAGE_BYTES + 1);
    localparam logic [NB_W-1:0] PAGE_LIM = NB_W'(PAGE_BYTES);

    typedef struct packed {
        logic              armed;
        logic [RSEL_W-1:0] arm_rsel;
        pend_e             pend;
        logic [RSEL_W-1:0] pend_rsel;
        logic [NB_W-1:0]   nbytes;
        logic              pv;
        logic [AW-1:0]     paddr;
        logic [7:0]        pdata;
    } ss_t;

    ss_t ss_d, ss_q;
    logic [N_REG-1:0] prot_d;
    logic [N_REG-1:0] prot_q = '0;

    phase_e            phase;
    logic              prog_end, hit, is_cmd, arm, dis;
    logic [RSEL_W-1:0] rsel;
    logic              rsel_ok, locked, allowed;

    assign rsel    = wr_addr[AW-1:REG_AW];
    assign hit     = wr_valid && (phase != PH_PROG);
    assign rsel_ok = (int'(rsel) < N_REG);

    wp_phase_timer #(
        .LOAD_WIN (LOAD_WIN),
        .PROG_CYC (PROG_CYC)
    ) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .phase_o    (phase),
        .prog_end_o (prog_end)
    );

    wp_cmd_match #(
        .REG_AW (REG_AW),
        .RSEL_W (RSEL_W)
    ) i_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .flush    (prog_end),
        .addr_lo  (wr_addr[REG_AW-1:0]),
        .rsel     (rsel),
        .data     (wr_data),
        .is_cmd_o (is_cmd),
        .arm_o    (arm),
        .dis_o    (dis)
    );

    always_comb begin
        locked  = rsel_ok ? prot_q[rsel] : 1'b1;
        allowed = rsel_ok && (!locked || (ss_q.armed && ss_q.arm_rsel == rsel))
                  && (ss_q.nbytes < PAGE_LIM);
    end

    always_comb begin
        ss_d    = ss_q;
        ss_d.pv = 1'b0;
        if (prog_end) begin
            ss_d.armed  = 1'b0;
            ss_d.pend   = PD_NONE;
            ss_d.nbytes = '0;
        end else if (hit) begin
            if (arm || dis) begin
                ss_d.armed     = 1'b1;
                ss_d.arm_rsel  = rsel;
                ss_d.pend      = arm ? PD_SET : PD_CLR;
                ss_d.pend_rsel = rsel;
            end else if (!is_cmd && allowed) begin
                ss_d.pv     = 1'b1;
                ss_d.paddr  = wr_addr;
                ss_d.pdata  = wr_data;
                ss_d.nbytes = ss_q.nbytes + 1'b1;
            end
        end
    end

    always_comb begin
        prot_d = prot_q;
        if (prog_end && ss_q.pend != PD_NONE) begin
            for (int i = 0; i < N_REG; i++) begin
                if (ss_q.pend_rsel == RSEL_W'(i)) prot_d[i] = (ss_q.pend == PD_SET);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ss_q.armed     <= 1'b0;
            ss_q.arm_rsel  <= '0;
            ss_q.pend      <= PD_NONE;
            ss_q.pend_rsel <= '0;
            ss_q.nbytes    <= '0;
            ss_q.pv        <= 1'b0;
            ss_q.paddr     <= '0;
            ss_q.pdata     <= '0;
        end else begin
            ss_q <= ss_d;
        end
    end

    always_ff @(posedge clk) begin
        prot_q <= prot_d;
    end

    assign pass_valid = ss_q.pv;
    assign pass_addr  = ss_q.paddr;
    assign pass_data  = ss_q.pdata;
    assign busy       = (phase != PH_IDLE);
    assign prog_busy  = (phase == PH_PROG);
    assign prot_flags = prot_q;

    // R3
    prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_end |=> $stable(prot_q));

    // R2
    pass_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> $past(wr_valid));

    // R7
    page_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_valid |-> (ss_q.nbytes <= PAGE_LIM));

    // R12
    prog_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PROG) |=> !pass_valid);
endmodule

// File: tb/test_wp_seq_top.sv
`timescale 1ns/1ps
module test_wp_seq_top;
    localparam int LW = 20;
    localparam int PC = 40;
    localparam int PB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        pass_valid;
    logic [17:0] pass_addr;
    logic [7:0]  pass_data;
    logic        busy, prog_busy;
    logic [1:0]  prot_flags;

    int n_chk = 0;
    int n_bad = 0;
    int npass = 0;
    logic [17:0] last_addr = '0;
    logic [7:0]  last_data = '0;

    always #10 clk = ~clk;

    wp_seq_top #(
        .N_REG(2), .REG_AW(17), .LOAD_WIN(LW), .PROG_CYC(PC), .PAGE_BYTES(PB)
    ) i_wp_seq_top (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .pass_valid(pass_valid), .pass_addr(pass_addr),
        .pass_data(pass_data), .busy(busy), .prog_busy(prog_busy),
        .prot_flags(prot_flags)
    );

    always @(negedge clk) begin
        if (pass_valid) begin
            npass     <= npass + 1;
            last_addr <= pass_addr;
            last_data <= pass_data;
        end
    end

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [17:0] a, input logic [7:0] d);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic prefix(input logic r);
        wr({r, 17'h05555}, 8'hAA);
        wr({r, 17'h02AAA}, 8'h55);
        wr({r, 17'h05555}, 8'hA0);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        // R1
        chk("R1 busy", busy == 1'b0, busy, 0);
        chk("R1 prog_busy", prog_busy == 1'b0, prog_busy, 0);
        chk("R1 pass_valid", pass_valid == 1'b0, pass_valid, 0);
        chk("R1 flags", prot_flags == 2'b00, prot_flags, 0);
    endtask

    task automatic t_plain();
        int b, n;
        b = npass;
        wr(18'h20010, 8'h3C);
        busy_len(n);
        // R2
        chk("R2 count", npass - b == 1, npass - b, 1);
        chk("R2 addr", last_addr == 18'h20010, last_addr, 18'h20010);
        chk("R2 data", last_data == 8'h3C, last_data, 8'h3C);
        // R11
        chk("R11 busy length", n == LW + PC, n, LW + PC);
    endtask

    task automatic t_retrigger();
        int n;
        wr(18'h20020, 8'h01);
        repeat (5) @(negedge clk);
        chk("R11 still loading", prog_busy == 1'b0, prog_busy, 0);
        wr(18'h20021, 8'h02);
        busy_len(n);
        chk("R11 restart", n == LW + PC, n, LW + PC);
    endtask

    task automatic t_prog_ignore();
        int b, n;
        wr(18'h20030, 8'h05);
        for (int i = 0; i < 100 && !prog_busy; i++) @(negedge clk);
        @(negedge clk);
        b = npass;
        wr(18'h20031, 8'h06);
        busy_len(n);
        // R12
        chk("R12 not forwarded", npass == b, npass - b, 0);
        chk("R12 no restart", n < PC, n, PC);
    endtask

    task automatic t_enable_r0();
        int b;
        b = npass;
        prefix(1'b0);
        wr(18'h00100, 8'h11);
        wr(18'h00101, 8'h22);
        // R3
        chk("R3 flag not yet", prot_flags == 2'b00, prot_flags, 0);
        wait_idle();
        chk("R3 only data passed", npass - b == 2, npass - b, 2);
        chk("R3 last data", last_data == 8'h22, last_data, 8'h22);
        chk("R3 flag set", prot_flags == 2'b01, prot_flags, 1);
    endtask

    task automatic t_locked();
        int b;
        b = npass;
        wr(18'h00200, 8'h99);
        // R5
        chk("R5 timing runs", busy == 1'b1, busy, 1);
        wait_idle();
        chk("R5 not forwarded", npass == b, npass - b, 0);
        chk("R5 flags", prot_flags == 2'b01, prot_flags, 1);
    endtask

    task automatic t_broken();
        int b;
        b = npass;
        wr(18'h25555, 8'hAA);
        wr(18'h22AAA, 8'h55);
        wr(18'h25555, 8'h33);
        wait_idle();
        // R9
        chk("R9 count", npass - b == 1, npass - b, 1);
        chk("R9 data", last_data == 8'h33, last_data, 8'h33);
        chk("R9 addr", last_addr == 18'h25555, last_addr, 18'h25555);
        chk("R9 flags", prot_flags == 2'b01, prot_flags, 1);
    endtask

    task automatic t_enable_only();
        prefix(1'b1);
        // R4
        chk("R4 before end", prot_flags == 2'b01, prot_flags, 1);
        wait_idle();
        chk("R4 flag set", prot_flags == 2'b11, prot_flags, 3);
    endtask

    task automatic t_unlock();
        int b;
        b = npass;
        prefix(1'b0);
        wr(18'h20400, 8'h41);
        wr(18'h20401, 8'h42);
        @(negedge clk);
        // R6
        chk("R6 other region locked", npass == b, npass - b, 0);
        for (int i = 0; i < 6; i++) wr(18'h00400 + 18'(i), 8'h50 + 8'(i));
        wait_idle();
        // R7
        chk("R7 page cap", npass - b == PB, npass - b, PB);
        chk("R7 last kept", last_data == 8'h53, last_data, 8'h53);
    endtask

    task automatic t_reset_keep();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10
        chk("R10 flags kept", prot_flags == 2'b11, prot_flags, 3);
        chk("R10 idle", busy == 1'b0, busy, 0);
    endtask

    task automatic t_disable();
        int b;
        b = npass;
        wr(18'h05555, 8'hAA);
        wr(18'h02AAA, 8'h55);
        wr(18'h05555, 8'h80);
        wr(18'h05555, 8'hAA);
        wr(18'h02AAA, 8'h55);
        wr(18'h05555, 8'h20);
        wr(18'h00300, 8'h5A);
        // R8
        chk("R8 before end", prot_flags == 2'b11, prot_flags, 3);
        wait_idle();
        chk("R8 data passed", npass - b == 1, npass - b, 1);
        chk("R8 flag cleared", prot_flags == 2'b10, prot_flags, 2);
        wr(18'h00301, 8'h6B);
        wait_idle();
        chk("R8 open writes", npass - b == 2, npass - b, 2);
    endtask

    initial begin
        #(20 * 20000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_retrigger();
        t_prog_ignore();
        t_enable_r0();
        t_locked();
        t_broken();
        t_enable_only();
        t_unlock();
        t_reset_keep();
        t_disable();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule